// File: doc/BRIEF.md
# Pipelined Byte-Lane Memory Slave

This block is a synchronous RAM target for a 32-bit processor bus that uses byte addresses. A transfer is offered in two steps. In the address cycle the master presents the byte address, a two-bit size code, a direction bit, a sequential flag and a lock flag. The slave registers them. In the next cycle, the data cycle, write data arrive or read data are returned, and an error flag shows whether the transfer was refused. Address and data cycles of successive transfers may overlap.

Writes can touch one byte, one halfword or the whole word, and they leave the other bytes of the word as they were. Reads return the addressed byte copied into every lane, or the addressed halfword copied into both halves. The slave ignores the low address bits that do not belong to the size of the transfer. It refuses a transfer, and suppresses its write, when the size code is reserved, when the word lies beyond the RAM, when a sequential transfer reverses the burst direction, or when a locked write does not follow a locked read of the same word.

Top module: `bytelane_mem_slave`

## Requirements
- R1: Request inputs are registered when `req_valid` is high. The matching write data are taken, and `rdata` and `err` are driven, only in the following cycle. `err` is low in any cycle that carries no data phase.
- R2: Size code 2 (word) moves all 32 bits. Address bits [1:0] are ignored.
- R3: Size code 1 (halfword) uses lanes {1,0} when address bit 1 is 0 and lanes {3,2} when it is 1. Address bit 0 is ignored. A write takes `wdata[15:0]`. A read returns the halfword in both halves of `rdata`.
- R4: Size code 0 (byte) uses lane addr[1:0], little-endian, with lane k at bits [8k+7:8k]. A write takes `wdata[7:0]` and leaves the other three bytes of the word unchanged. A read returns the byte in all four lanes.
- R5: Size code 3 is reserved. It raises `err` and writes nothing.
- R6: A word index addr[31:2] at or above `DEPTH_WORDS` raises `err`, writes nothing and reads as 0.
- R7: A transfer with `seq` high and `lock` low whose direction (`write`: 1 = write, 0 = read) differs from the previous transfer raises `err`. Its write is suppressed and its read returns 0.
- R8: A write with `lock` high raises `err`, and is suppressed, unless the transfer just before it was an error-free locked read of the same word.
- R9: After reset `err` and `rdata` are 0 and no data phase is pending.
- R10: A sequential word burst at addresses n, n+4, n+8 writes and reads consecutive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present in this address cycle |
| addr | input | 32 | Byte address of the request |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| write | input | 1 | 1 write, 0 read |
| seq | input | 1 | Request continues the current burst |
| lock | input | 1 | Request is part of an atomic swap |
| wdata | input | 32 | Write data, valid in the data cycle |
| rdata | output | 32 | Read data in the data cycle, 0 otherwise |
| err | output | 1 | Transfer refused, data cycle only |

## Verification
The bench builds the block with `DEPTH_WORDS` = 16. That puts the top of the RAM at byte 0x3C, so the last valid word and the first out-of-range word at 0x40 are both one short transfer away. A small depth also means a burst that starts at word 0 reaches the burst and lock tests quickly. The 32-bit address width is kept, so the range check still compares the full word index.

// File: rtl/smem_pkg.sv
// Shared types for the byte-lane memory slave.
// Assumes a 32-bit byte-addressed bus with a two-bit size code.
package smem_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        xfer_size_e        size;
        logic              write;
        logic              seq;
        logic              lock;
    } bus_req_t;
endpackage

// File: rtl/smem_addr_stage.sv
// Address-phase register: captures the request one cycle ahead of its data phase.
// Assumes the master holds request signals stable around the clock edge.
module smem_addr_stage
    import smem_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  bus_req_t req_in,
    output logic     dph_valid,
    output bus_req_t dph_req
);
    // Register the request so the data phase sees it in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dph_valid <= 1'b0;
            dph_req   <= '0;
        end else begin
            dph_valid <= req_valid;
            if (req_valid) dph_req <= req_in;
        end
    end

    p_pipe_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dph_valid);
    p_pipe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dph_valid);
endmodule

// File: rtl/smem_lane_decode.sv
// Lane decoder: turns the registered size and address into byte enables,
// a word index and error causes, and formats the write and read data.
// Assumes little-endian lanes, with lane k at bits [8k+7:8k].
module smem_lane_decode
    import smem_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    localparam int IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] ram_word,
    output logic [LANES-1:0]  be,
    output logic [IDX_W-1:0]  word_idx,
    output logic              size_bad,
    output logic              range_bad,
    output logic [DATA_W-1:0] wdata_lanes,
    output logic [DATA_W-1:0] rdata_fmt
);
    logic [ADDR_W-3:0] full_idx;
    logic [7:0]        sel_byte;
    logic [15:0]       sel_half;

    // Word index and range check on the whole upper address.
    always_comb begin
        full_idx  = req.addr[ADDR_W-1:2];
        word_idx  = full_idx[IDX_W-1:0];
        range_bad = ({2'b00, full_idx} >= ADDR_W'(DEPTH_WORDS));
        size_bad  = (req.size == SZ_RSVD);
    end

    // Byte enables follow the size, with the redundant low bits ignored.
    always_comb begin
        unique case (req.size)
            SZ_BYTE: be = 4'b0001 << req.addr[1:0];
            SZ_HALF: be = req.addr[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: be = 4'b1111;
            default: be = 4'b0000;
        endcase
    end

    // Copy the low write data into every lane so the enables can steer it.
    always_comb begin
        unique case (req.size)
            SZ_BYTE: wdata_lanes = {4{wdata_in[7:0]}};
            SZ_HALF: wdata_lanes = {2{wdata_in[15:0]}};
            default: wdata_lanes = wdata_in;
        endcase
    end

    // Pick the addressed byte or halfword and copy it across the read bus.
    always_comb begin
        sel_byte = ram_word[8*req.addr[1:0] +: 8];
        sel_half = req.addr[1] ? ram_word[31:16] : ram_word[15:0];
        unique case (req.size)
            SZ_BYTE: rdata_fmt = {4{sel_byte}};
            SZ_HALF: rdata_fmt = {2{sel_half}};
            default: rdata_fmt = ram_word;
        endcase
    end

    p_be_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && req.size == SZ_WORD) |-> be == 4'hF);
    p_be_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && req.size == SZ_HALF) |-> ($countones(be) == 2 && (be[0] == be[1])));
    p_be_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && req.size == SZ_BYTE) |-> $countones(be) == 1);
endmodule

// File: rtl/smem_byte_ram.sv
// Byte-writable RAM: one 8-bit array per lane, written on its own enable,
// read asynchronously. Assumes the index is already range-checked.
module smem_byte_ram
    import smem_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    localparam int IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] mem [DEPTH_WORDS];

        // Write this lane only when its enable is set.
        always_ff @(posedge clk) begin
            if (we && be[l]) mem[idx] <= wdata[8*l +: 8];
        end

        assign rdata[8*l +: 8] = mem[idx];
    end
endmodule

// File: rtl/bytelane_mem_slave.sv
// Top of the pipelined byte-lane memory slave. It registers requests,
// decodes lanes, checks burst direction and locked swaps, and gates
// writes and read data on the error flag.
// Assumes the write data arrive in the cycle after the request.
module bytelane_mem_slave
    import smem_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    localparam int IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    input  logic        write,
    input  logic        seq,
    input  logic        lock,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        err
);
    bus_req_t          req_in, dph_req;
    logic              dph_valid;
    logic [LANES-1:0]  be;
    logic [IDX_W-1:0]  word_idx, prev_idx;
    logic              size_bad, range_bad, dir_bad, lock_bad, err_now;
    logic              prev_valid, prev_write, prev_lkrd, ram_we;
    logic [DATA_W-1:0] wdata_lanes, ram_word, rdata_fmt;

    // Pack the request inputs.
    always_comb begin
        req_in.addr  = addr;
        req_in.size  = xfer_size_e'(size);
        req_in.write = write;
        req_in.seq   = seq;
        req_in.lock  = lock;
    end

    smem_addr_stage u_addr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(req_in),
        .dph_valid(dph_valid), .dph_req(dph_req)
    );

    smem_lane_decode #(.DEPTH_WORDS(DEPTH_WORDS)) u_dec (
        .clk(clk), .rst_n(rst_n), .active(dph_valid), .req(dph_req),
        .wdata_in(wdata), .ram_word(ram_word), .be(be), .word_idx(word_idx),
        .size_bad(size_bad), .range_bad(range_bad),
        .wdata_lanes(wdata_lanes), .rdata_fmt(rdata_fmt)
    );

    smem_byte_ram #(.DEPTH_WORDS(DEPTH_WORDS)) u_ram (
        .clk(clk), .we(ram_we), .be(be), .idx(word_idx),
        .wdata(wdata_lanes), .rdata(ram_word)
    );

    // Record the last transfer for the burst-direction and swap checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_write <= 1'b0;
            prev_lkrd  <= 1'b0;
            prev_idx   <= '0;
        end else if (dph_valid) begin
            prev_valid <= 1'b1;
            prev_write <= dph_req.write;
            prev_lkrd  <= dph_req.lock && !dph_req.write && !err_now;
            prev_idx   <= word_idx;
        end
    end

    // Combine the error causes and gate the write and read paths.
    always_comb begin
        dir_bad  = dph_req.seq && !dph_req.lock && prev_valid &&
                   (dph_req.write != prev_write);
        lock_bad = dph_req.lock && dph_req.write &&
                   !(prev_lkrd && (prev_idx == word_idx));
        err_now  = dph_valid && (size_bad || range_bad || dir_bad || lock_bad);
        ram_we   = dph_valid && dph_req.write && !err_now;
        rdata    = (dph_valid && !dph_req.write && !err_now) ? rdata_fmt : '0;
        err      = err_now;
    end

    p_rsvd_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dph_valid && dph_req.size == SZ_RSVD) |-> (err && !ram_we));
    p_range_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dph_valid && range_bad) |-> (rdata == '0 && !ram_we));
    p_dir_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dph_valid && dph_req.seq && !dph_req.lock && prev_valid &&
         dph_req.write != prev_write) |-> (err && !ram_we));
    p_lock_orphan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dph_valid && dph_req.lock && dph_req.write && !prev_lkrd) |-> !ram_we);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dph_valid |-> (!err && rdata == '0));
endmodule

// File: tb/bytelane_mem_slave_tb_top.sv
// Directed bench for the byte-lane memory slave, one task per scenario.
module bytelane_mem_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic        write = 1'b0, seq = 1'b0, lock = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    bytelane_mem_slave #(.DEPTH_WORDS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr(addr),
        .size(size), .write(write), .seq(seq), .lock(lock),
        .wdata(wdata), .rdata(rdata), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One transfer: address cycle, then data cycle sampled at its falling edge.
    task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic sq, input logic lk, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; addr = a; size = sz; write = wr; seq = sq; lock = lk;
        wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        req_valid = 1'b0; addr = 32'hFFFF_FFFF; wdata = wd;
        @(negedge clk);
        rd = rdata; er = err;
    endtask

    task automatic t_reset();
        chk("R9 err after reset", {31'b0, err}, 32'd0);
        chk("R9 rdata after reset", rdata, 32'd0);
    endtask

    task automatic t_word();
        logic [31:0] rd; logic er;
        xfer(32'h10, 2'd2, 1'b1, 1'b0, 1'b0, 32'hA5A5_1234, rd, er);
        chk("R2 word write err", {31'b0, er}, 32'd0);
        xfer(32'h13, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R2 word read low bits ignored", rd, 32'hA5A5_1234);
    endtask

    task automatic t_half();
        logic [31:0] rd; logic er;
        xfer(32'h20, 2'd2, 1'b1, 1'b0, 1'b0, 32'h1122_3344, rd, er);
        xfer(32'h23, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_BEEF, rd, er);
        xfer(32'h20, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R3 upper half written", rd, 32'hBEEF_3344);
        xfer(32'h22, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R3 half read copied", rd, 32'hBEEF_BEEF);
        xfer(32'h21, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R3 lower half bit0 ignored", rd, 32'h3344_3344);
    endtask

    task automatic t_byte();
        logic [31:0] rd; logic er;
        xfer(32'h30, 2'd2, 1'b1, 1'b0, 1'b0, 32'h1122_3344, rd, er);
        xfer(32'h31, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_005A, rd, er);
        xfer(32'h30, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R4 byte lane1 only", rd, 32'h1122_5A44);
        xfer(32'h33, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R4 byte lane3 copied", rd, 32'h1111_1111);
    endtask

    // The address cycle of the reserved request must not show err.
    task automatic t_rsvd();
        logic [31:0] rd; logic er;
        @(negedge clk);
        req_valid = 1'b1; addr = 32'h30; size = 2'd3; write = 1'b1; seq = 1'b0; lock = 1'b0;
        #2 chk("R1 no err in address cycle", {31'b0, err}, 32'd0);
        @(posedge clk); #1;
        req_valid = 1'b0; wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        chk("R5 reserved size err", {31'b0, err}, 32'd1);
        xfer(32'h30, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R5 reserved size no write", rd, 32'h1122_5A44);
    endtask

    task automatic t_range();
        logic [31:0] rd; logic er;
        xfer(32'h3C, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0BAD_F00D, rd, er);
        chk("R6 last word ok", {31'b0, er}, 32'd0);
        xfer(32'h40, 2'd2, 1'b1, 1'b0, 1'b0, 32'h1357_9BDF, rd, er);
        chk("R6 out of range write err", {31'b0, er}, 32'd1);
        xfer(32'h40, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R6 out of range read err", {31'b0, er}, 32'd1);
        chk("R6 out of range read zero", rd, 32'd0);
        xfer(32'h00, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R6 alias word0 untouched", (rd == 32'h1357_9BDF) ? 32'd1 : 32'd0, 32'd0);
    endtask

    task automatic t_burst();
        logic [31:0] rd; logic er;
        xfer(32'h00, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_0A00, rd, er);
        xfer(32'h04, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_0A04, rd, er);
        xfer(32'h08, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_0A08, rd, er);
        chk("R10 burst write err", {31'b0, er}, 32'd0);
        xfer(32'h0C, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0, rd, er);
        chk("R7 read in write burst err", {31'b0, er}, 32'd1);
        xfer(32'h00, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R10 burst word0", rd, 32'h0000_0A00);
        xfer(32'h04, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0, rd, er);
        chk("R10 burst word1", rd, 32'h0000_0A04);
        xfer(32'h08, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_DEAD, rd, er);
        chk("R7 write in read burst err", {31'b0, er}, 32'd1);
        xfer(32'h08, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R7 suppressed write", rd, 32'h0000_0A08);
    endtask

    task automatic t_lock();
        logic [31:0] rd; logic er;
        xfer(32'h08, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0, rd, er);
        chk("R8 locked read data", rd, 32'h0000_0A08);
        xfer(32'h08, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_5555, rd, er);
        chk("R8 swap write ok", {31'b0, er}, 32'd0);
        xfer(32'h04, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_7777, rd, er);
        chk("R8 orphan locked write err", {31'b0, er}, 32'd1);
        xfer(32'h08, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R8 swap stored", rd, 32'h0000_5555);
        xfer(32'h04, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, rd, er);
        chk("R8 orphan not stored", rd, 32'h0000_0A04);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_half();
        t_byte();
        t_rsvd();
        t_range();
        t_burst();
        t_lock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule